// File: doc/BRIEF.md
# Single-wire bus master slot engine

This block is the controlling end of an open-drain single-wire bus. A host asks for one bus operation at a time: a bus reset with presence detection, a write-0 slot, a write-1 slot or a read slot. The block produces the low pulse that the operation needs and holds the recovery gap after it. It samples the line at a fixed point in the slot and reports the read bit or the presence flag with a one-cycle done pulse.

All timing is counted in ticks of a clock-enable input that pulses once every half microsecond. Standard or overdrive timing is chosen per operation by an input that is captured at start. The block never drives the line high. It only asserts a drive-low enable. It reads the line back through a two-flop synchronizer.

Top module: `ow_master`

## Requirements
- R1: After reset, busy_o, done_o, drive_low_o, rd_bit_o and presence_o are all 0.
- R2: A start_i seen while busy_o is 0 is accepted. busy_o is 1 in the next cycle and drive_low_o is asserted in that same cycle.
- R3: Command 0 (bus reset) drives the line low for 960 ticks at standard speed. The line is then released, and busy_o covers 1920 ticks in total. drive_low_o is never 1 while busy_o is 0.
- R4: For a bus reset, presence_o is set to 1 if the synchronized line is low at tick 1100 of the operation (157 at overdrive), and to 0 otherwise. presence_o changes only in the cycle where done_o is 1.
- R5: Command 1 (write-0) holds the line low for 130 ticks, then releases it for a 10-tick recovery gap.
- R6: Command 2 (write-1) holds the line low for 12 ticks, then releases it for the rest of the 140-tick slot.
- R7: Command 3 (read) holds the line low for 12 ticks. It returns on rd_bit_o the synchronized line level seen at tick 26 of the slot.
- R8: done_o is a one-cycle pulse in the cycle where busy_o falls. A start_i given in that cycle is accepted.
- R9: With od_i at 1 when the command starts, overdrive timing applies. Reset is 140 ticks low in a 280-tick operation with presence sampled at tick 157. Slots are 16 ticks with a 2-tick recovery. Write-0 is 16 ticks low. Write-1 and read are 2 ticks low. Read samples at tick 3.
- R10: start_i, cmd_i and od_i have no effect while busy_o is 1.
- R11: Operation time advances only in cycles where tick_i is 1. With tick_i held at 0, drive_low_o and busy_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Half-microsecond clock enable |
| start_i | input | 1 | Start strobe for one operation |
| cmd_i | input | 2 | 0 reset, 1 write-0, 2 write-1, 3 read |
| od_i | input | 1 | 1 selects overdrive timing |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_bit_o | output | 1 | Last bit read |
| presence_o | output | 1 | Presence seen after the last bus reset |
| line_i | input | 1 | Bus line level |
| drive_low_o | output | 1 | Open-drain pull-down enable |

## Verification
busy_o and drive_low_o respond one cycle after an accepted start. Each later drive_low_o edge follows the tick whose edge brings the count to the low length. done_o and the result flags change at the edge of the tick that ends the operation. Sampled results reflect the line level two edges before the sample tick, because of the synchronizer. A behavioural model in the bench advances on the same edges. It is compared with every output half a cycle after each edge. The bench slave pulls the line low over windows wide enough that the synchronizer delay cannot move a sampled value.

// File: rtl/ow_pkg.sv
package ow_pkg;
  localparam int unsigned OW_TW = 16;

  typedef enum logic [1:0] {
    OW_RESET = 2'd0,
    OW_WR0   = 2'd1,
    OW_WR1   = 2'd2,
    OW_READ  = 2'd3
  } ow_cmd_e;

  typedef struct packed {
    logic [OW_TW-1:0] low;
    logic [OW_TW-1:0] samp;
    logic [OW_TW-1:0] last;
  } ow_win_t;
endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ow_timing_sel.sv
module ow_timing_sel
  import ow_pkg::*;
#(
  parameter int unsigned ST_RST_LOW  = 960,
  parameter int unsigned ST_RST_SAMP = 1100,
  parameter int unsigned ST_RST_TOT  = 1920,
  parameter int unsigned ST_SLOT     = 130,
  parameter int unsigned ST_SHORT    = 12,
  parameter int unsigned ST_RD_SAMP  = 26,
  parameter int unsigned ST_REC      = 10,
  parameter int unsigned OD_RST_LOW  = 140,
  parameter int unsigned OD_RST_SAMP = 157,
  parameter int unsigned OD_RST_TOT  = 280,
  parameter int unsigned OD_SLOT     = 16,
  parameter int unsigned OD_SHORT    = 2,
  parameter int unsigned OD_RD_SAMP  = 3,
  parameter int unsigned OD_REC      = 2
) (
  input  ow_cmd_e cmd_i,
  input  logic    od_i,
  output ow_win_t win_o
);
  ow_win_t rst_w [2];
  ow_win_t slot_w [2][4];

  // index 0: standard, 1: overdrive
  for (genvar s = 0; s < 2; s++) begin : g_speed
    localparam int unsigned RL = (s == 0) ? ST_RST_LOW  : OD_RST_LOW;
    localparam int unsigned RS = (s == 0) ? ST_RST_SAMP : OD_RST_SAMP;
    localparam int unsigned RT = (s == 0) ? ST_RST_TOT  : OD_RST_TOT;
    localparam int unsigned SL = (s == 0) ? ST_SLOT     : OD_SLOT;
    localparam int unsigned SH = (s == 0) ? ST_SHORT    : OD_SHORT;
    localparam int unsigned DS = (s == 0) ? ST_RD_SAMP  : OD_RD_SAMP;
    localparam int unsigned RC = (s == 0) ? ST_REC      : OD_REC;
    assign rst_w[s] = '{low: OW_TW'(RL), samp: OW_TW'(RS), last: OW_TW'(RT - 1)};
    assign slot_w[s][0] = rst_w[s];
    assign slot_w[s][1] = '{low: OW_TW'(SL), samp: OW_TW'(DS), last: OW_TW'(SL + RC - 1)};
    assign slot_w[s][2] = '{low: OW_TW'(SH), samp: OW_TW'(DS), last: OW_TW'(SL + RC - 1)};
    assign slot_w[s][3] = '{low: OW_TW'(SH), samp: OW_TW'(DS), last: OW_TW'(SL + RC - 1)};
  end

  assign win_o = slot_w[od_i][cmd_i];
endmodule

// File: rtl/ow_tick_cnt.sv
module ow_tick_cnt #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [TW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ow_master.sv
module ow_master
  import ow_pkg::*;
#(
  parameter int unsigned ST_RST_LOW  = 960,
  parameter int unsigned ST_RST_SAMP = 1100,
  parameter int unsigned ST_RST_TOT  = 1920,
  parameter int unsigned ST_SLOT     = 130,
  parameter int unsigned ST_SHORT    = 12,
  parameter int unsigned ST_RD_SAMP  = 26,
  parameter int unsigned ST_REC      = 10,
  parameter int unsigned OD_RST_LOW  = 140,
  parameter int unsigned OD_RST_SAMP = 157,
  parameter int unsigned OD_RST_TOT  = 280,
  parameter int unsigned OD_SLOT     = 16,
  parameter int unsigned OD_SHORT    = 2,
  parameter int unsigned OD_RD_SAMP  = 3,
  parameter int unsigned OD_REC      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [1:0] cmd_i,
  input  logic       od_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       rd_bit_o,
  output logic       presence_o,
  input  logic       line_i,
  output logic       drive_low_o
);
  logic             busy_q, done_q, od_q, smp_q, rd_q, pres_q;
  ow_cmd_e          cmd_q;
  logic [OW_TW-1:0] cnt_q;
  ow_win_t          win;
  logic             line_s, accept, step, fin, smp_hit;

  ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(line_s)
  );

  ow_timing_sel #(
    .ST_RST_LOW(ST_RST_LOW), .ST_RST_SAMP(ST_RST_SAMP), .ST_RST_TOT(ST_RST_TOT),
    .ST_SLOT(ST_SLOT), .ST_SHORT(ST_SHORT), .ST_RD_SAMP(ST_RD_SAMP), .ST_REC(ST_REC),
    .OD_RST_LOW(OD_RST_LOW), .OD_RST_SAMP(OD_RST_SAMP), .OD_RST_TOT(OD_RST_TOT),
    .OD_SLOT(OD_SLOT), .OD_SHORT(OD_SHORT), .OD_RD_SAMP(OD_RD_SAMP), .OD_REC(OD_REC)
  ) u_tsel (
    .cmd_i(cmd_q), .od_i(od_q), .win_o(win)
  );

  assign accept  = start_i & ~busy_q;
  assign step    = busy_q & tick_i;
  assign fin     = step & (cnt_q == win.last);
  assign smp_hit = step & (cnt_q == win.samp);

  ow_tick_cnt #(.TW(OW_TW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .inc_i(step & ~fin), .cnt_o(cnt_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cmd_q  <= OW_RESET;
      od_q   <= 1'b0;
      smp_q  <= 1'b1;
      rd_q   <= 1'b0;
      pres_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (accept) begin
        busy_q <= 1'b1;
        cmd_q  <= ow_cmd_e'(cmd_i);
        od_q   <= od_i;
      end else if (fin) begin
        busy_q <= 1'b0;
        if (cmd_q == OW_RESET) pres_q <= ~smp_q;
        if (cmd_q == OW_READ)  rd_q   <= smp_q;
      end
      if (smp_hit) smp_q <= line_s;
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign rd_bit_o    = rd_q;
  assign presence_o  = pres_q;
  assign drive_low_o = busy_q & (cnt_q < win.low);
endmodule

// File: rtl/ow_master_chk.sv
module ow_master_chk
  import ow_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             drive_low_o,
  input logic             presence_o,
  input logic             rd_bit_o,
  input ow_cmd_e          cmd_q,
  input logic [OW_TW-1:0] cnt_q
);
  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_drive_in_op_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_low_o |-> busy_o);

  assert_result_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(presence_o) && $stable(rd_bit_o)));

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_cmd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cmd_q));

  assert_no_tick_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> $stable(cnt_q));
endmodule

bind ow_master ow_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .drive_low_o(drive_low_o),
  .presence_o(presence_o), .rd_bit_o(rd_bit_o), .cmd_q(cmd_q), .cnt_q(cnt_q)
);

// File: tb/test_ow_master.sv
module test_ow_master;
  logic       clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, start_i = 1'b0, od_i = 1'b0;
  logic       line_i = 1'b1;
  logic [1:0] cmd_i = 2'd0;
  logic       busy_o, done_o, rd_bit_o, presence_o, drive_low_o;

  ow_master i_ow_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i), .cmd_i(cmd_i),
    .od_i(od_i), .busy_o(busy_o), .done_o(done_o), .rd_bit_o(rd_bit_o),
    .presence_o(presence_o), .line_i(line_i), .drive_low_o(drive_low_o)
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit tick_en = 1'b1, slave_pres = 1'b0, slave_bit = 1'b1;

  // behavioural reference, half-microsecond units from the requirements
  int m_cnt = 0;
  bit m_busy = 0, m_done = 0, m_pres = 0, m_rd = 0, m_smp = 1, m_od = 0, l1 = 1, l2 = 1, s_now;
  int m_cmd = 0;

  function automatic int t_low(int c, bit o);
    if (c == 0) return o ? 140 : 960;
    if (c == 1) return o ? 16 : 130;
    return o ? 2 : 12;
  endfunction
  function automatic int t_samp(int c, bit o);
    if (c == 0) return o ? 157 : 1100;
    return o ? 3 : 26;
  endfunction
  function automatic int t_tot(int c, bit o);
    if (c == 0) return o ? 280 : 1920;
    return o ? 18 : 140;
  endfunction
  function automatic string req_of(int c, bit o);
    if (o) return "R9";
    case (c)
      0: return "R3";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_busy = 0; m_done = 0; m_pres = 0; m_rd = 0; m_smp = 1; l1 = 1; l2 = 1;
    end else begin
      s_now = l2; l2 = l1; l1 = line_i;
      m_done = 0;
      if (!m_busy) begin
        if (start_i) begin m_busy = 1; m_cnt = 0; m_cmd = int'(cmd_i); m_od = od_i; end
      end else if (tick_i) begin
        if (m_cnt == t_samp(m_cmd, m_od)) m_smp = s_now;
        if (m_cnt == t_tot(m_cmd, m_od) - 1) begin
          m_busy = 0; m_done = 1;
          if (m_cmd == 0) m_pres = !m_smp;
          if (m_cmd == 3) m_rd = m_smp;
        end else m_cnt++;
      end
    end
  end

  // compare every cycle, then drive line and tick away from the active edge
  always @(negedge clk_i) begin
    bit slave_low, exp_low;
    if (rst_ni) begin
      exp_low = m_busy && (m_cnt < t_low(m_cmd, m_od));
      chk(drive_low_o == exp_low, m_busy ? req_of(m_cmd, m_od) : "R3", "drive_low", drive_low_o, exp_low);
      chk(busy_o == m_busy, "R2", "busy", busy_o, m_busy);
      chk(done_o == m_done, "R8", "done", done_o, m_done);
      chk(presence_o == m_pres, "R4", "presence", presence_o, m_pres);
      chk(rd_bit_o == m_rd, "R7", "rd_bit", rd_bit_o, m_rd);
    end
    slave_low = m_busy && (
      (m_cmd == 0 && slave_pres && m_cnt >= t_low(0, m_od) + 4 && m_cnt <= t_samp(0, m_od) + 8) ||
      (m_cmd == 3 && !slave_bit && m_cnt <= t_samp(3, m_od) + 4));
    line_i = !(drive_low_o || slave_low);
    tick_i = tick_en ? ~tick_i : 1'b0;
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic wait_done();
    while (!done_o) @(negedge clk_i);
  endtask

  task automatic run(int c, bit o);
    @(negedge clk_i);
    start_i = 1'b1; cmd_i = 2'(c); od_i = o;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o && drive_low_o, "R2", "busy and low after start", busy_o, 1);
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !drive_low_o && !rd_bit_o && !presence_o, "R1",
        "outputs after reset", {busy_o, done_o, drive_low_o, rd_bit_o, presence_o}, 0);

    slave_pres = 1'b1; run(0, 0);
    chk(presence_o == 1'b1, "R4", "presence std", presence_o, 1);
    slave_pres = 1'b0; run(0, 0);
    chk(presence_o == 1'b0, "R4", "no presence std", presence_o, 0);

    run(1, 0);
    run(2, 0);
    slave_bit = 1'b0; run(3, 0);
    chk(rd_bit_o == 1'b0, "R7", "read 0 std", rd_bit_o, 0);
    slave_bit = 1'b1; run(3, 0);
    chk(rd_bit_o == 1'b1, "R7", "read 1 std", rd_bit_o, 1);

    slave_pres = 1'b1; run(0, 1);
    chk(presence_o == 1'b1, "R9", "presence od", presence_o, 1);
    run(1, 1);
    run(2, 1);
    slave_bit = 1'b0; run(3, 1);
    chk(rd_bit_o == 1'b0, "R9", "read 0 od", rd_bit_o, 0);
    slave_bit = 1'b1; run(3, 1);
    chk(rd_bit_o == 1'b1, "R9", "read 1 od", rd_bit_o, 1);

    // R10: restart with other command and speed mid-slot
    slave_bit = 1'b0;
    @(negedge clk_i); start_i = 1'b1; cmd_i = 2'd3; od_i = 1'b0;
    @(negedge clk_i); start_i = 1'b0;
    repeat (40) @(negedge clk_i);
    start_i = 1'b1; cmd_i = 2'd1; od_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(busy_o && !drive_low_o, "R10", "restart ignored", drive_low_o, 0);
    wait_done();
    chk(rd_bit_o == 1'b0, "R10", "read kept after ignored start", rd_bit_o, 0);
    slave_bit = 1'b1;

    // R11: freeze ticks inside write-0 low phase
    @(negedge clk_i); start_i = 1'b1; cmd_i = 2'd1; od_i = 1'b0;
    @(negedge clk_i); start_i = 1'b0;
    repeat (10) @(negedge clk_i);
    tick_en = 1'b0;
    repeat (300) @(negedge clk_i);
    chk(busy_o && drive_low_o, "R11", "held without tick", drive_low_o, 1);
    tick_en = 1'b1;
    wait_done();

    // R8: start in the done cycle
    start_i = 1'b1; cmd_i = 2'd2; od_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(busy_o && !done_o, "R8", "back-to-back accept", busy_o, 1);
    wait_done();

    repeat (5) @(negedge clk_i);
    finish_run();
  end
endmodule